// File: doc/BRIEF.md
# Dual Cascadable 8-bit Interval Timer

This block contains two 8-bit up-counters, timer A and timer B, and one shared prescaler. Each timer has its own run bit, its own clock-source select and its own compare register. When a timer's count reaches the last value before its compare value, the next tick sets the count back to zero. On that same tick the timer raises a one-cycle interrupt pulse. The time between pulses is therefore the compare value multiplied by the period of the selected tick.

The prescaler produces single-cycle enable strobes. It does not produce derived clocks. Its base strobe fires once every `BASE_DIV` system clocks, and further taps divide that base strobe by 4, 16 and 256. The prescaler runs only while at least one timer is running. When both timers are stopped, it is held at zero.

Timer A counts one of three prescaler taps or the synchronised rising edges of an external pin. Timer B counts one of three other taps or timer A's match events. Using timer A's matches chains the two counters into a longer period. Software programs the block through a small write-only port. It must stop a timer before changing that timer's compare value or clock source.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both timers are stopped, both compare values are 0 and both selects are 0. Neither irqA nor irqB pulses until a run bit is set.
- R2: The run bits are at address 0: bit 0 for timer A and bit 1 for timer B. The base prescaler strobe fires every 4 system clocks. Timer A select 1 (address 1, bits 1:0) counts this strobe, so with compare C, irqA pulses every 4*C clocks. If both timers were stopped beforehand, the first pulse comes 4*C clock edges after the edge that sets the run bit.
- R3: Timer A select 2 counts the divide-by-4 tap and select 3 counts the divide-by-16 tap. The resulting periods are 16*C and 64*C clocks.
- R4: Timer B's select is at address 1, bits 3:2, and its compare value is at address 3. Select values 1, 2 and 3 count the divide-by-1, divide-by-16 and divide-by-256 taps. The resulting periods are 4*C, 64*C and 1024*C clocks.
- R5: A compare value of 0 gives a period of 256 ticks.
- R6: Timer A select 0 counts rising edges of extIn after a two-flop synchroniser. A level held high counts once. Prescaler strobes are not counted in this mode.
- R7: Timer B select 0 counts timer A match events. Every irqB pulse coincides with an irqA pulse. If both timers start together, the first irqB comes CA*CB timer A ticks after the start.
- R8: Each interrupt is high for exactly one clock. It repeats every period for as long as the run bit stays set.
- R9: Clearing a run bit stops that timer and clears its count to zero. No pulse arrives while it is stopped. After a restart, a full period of ticks is needed before the next pulse.
- R10: Timer A's compare value is written at address 2. A compare write to a stopped timer takes effect immediately. A compare write to a running timer is ignored.
- R11: A select-field write to a running timer is ignored.
- R12: When both timers run from prescaler taps, each keeps its own period regardless of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 run, 1 select, 2 compare A, 3 compare B |
| wrData | input | 8 | Write data |
| extIn | input | 1 | External count input for timer A |
| irqA | output | 1 | Timer A match pulse |
| irqB | output | 1 | Timer B match pulse |

## Verification
The following properties are checked on every cycle:
- the single-cycle width of both interrupts;
- silence of a timer that has been stopped for more than one cycle;
- the freezing of compare values and select fields while a timer runs;
- the coincidence of irqB with irqA in cascade mode;
- the spacing of the base strobe.

Some behaviours can only be shown by the bench's scenarios:
- exact periods and start-up latencies for each tap and each compare value, including 0;
- counting of external edges only;
- the cleared count after a stop;
- the combined period of the cascaded timers.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int CNT_W = 8;

  localparam logic [1:0] ADDR_RUN  = 2'd0;
  localparam logic [1:0] ADDR_SEL  = 2'd1;
  localparam logic [1:0] ADDR_CMPA = 2'd2;
  localparam logic [1:0] ADDR_CMPB = 2'd3;

  typedef struct packed {
    logic tick1;
    logic tick4;
    logic tick16;
    logic tick256;
  } tapStrobes_t;

  typedef struct packed {
    logic             run;
    logic [1:0]       sel;
    logic [CNT_W-1:0] cmp;
  } timerCfg_t;

  typedef struct packed {
    tapStrobes_t taps;
    timerCfg_t   cfgA;
    timerCfg_t   cfgB;
  } ctrlBus_t;
endpackage

// File: rtl/dit_ctrl.sv
module dit_ctrl
  import dit_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int LOG_MID  = 2,
  parameter int LOG_HI   = 4,
  parameter int LOG_TOP  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output ctrlBus_t   bus
);
  localparam int BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

  logic             runA, runB;
  logic [1:0]       selA, selB;
  logic [CNT_W-1:0] cmpA, cmpB;
  logic [BASE_W-1:0]  baseCnt;
  logic [LOG_TOP-1:0] tapCnt;
  logic anyRun, baseWrap;

  // register file: compare and select frozen while the owning timer runs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runA <= 1'b0;
      runB <= 1'b0;
      selA <= '0;
      selB <= '0;
      cmpA <= '0;
      cmpB <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_RUN: begin
          runA <= wrData[0];
          runB <= wrData[1];
        end
        ADDR_SEL: begin
          if (!runA) selA <= wrData[1:0];
          if (!runB) selB <= wrData[3:2];
        end
        ADDR_CMPA: if (!runA) cmpA <= wrData[CNT_W-1:0];
        default:   if (!runB) cmpB <= wrData[CNT_W-1:0];
      endcase
    end
  end

  assign anyRun   = runA | runB;
  assign baseWrap = (baseCnt == BASE_LAST);

  // shared prescaler, held at zero while both timers are idle
  always_ff @(posedge clk) begin
    if (!rstN || !anyRun) begin
      baseCnt <= '0;
      tapCnt  <= '0;
    end else begin
      baseCnt <= baseWrap ? '0 : baseCnt + BASE_W'(1);
      if (baseWrap) tapCnt <= tapCnt + LOG_TOP'(1);
    end
  end

  always_comb begin
    bus.taps.tick1   = anyRun & baseWrap;
    bus.taps.tick4   = bus.taps.tick1 & (&tapCnt[LOG_MID-1:0]);
    bus.taps.tick16  = bus.taps.tick1 & (&tapCnt[LOG_HI-1:0]);
    bus.taps.tick256 = bus.taps.tick1 & (&tapCnt);
    bus.cfgA.run = runA;
    bus.cfgA.sel = selA;
    bus.cfgA.cmp = cmpA;
    bus.cfgB.run = runB;
    bus.cfgB.sel = selB;
    bus.cfgB.cmp = cmpB;
  end
endmodule

// File: rtl/dit_lane.sv
module dit_lane #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] cmp,
  output logic          match,
  output logic          irq
);
  logic [CW-1:0] count;
  logic [CW-1:0] lastVal;

  // compare 0 wraps to all-ones, giving a full 2**CW period
  assign lastVal = cmp - CW'(1);
  assign match   = run & tick & (count == lastVal);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      count <= '0;
    end else if (tick) begin
      count <= match ? '0 : count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= match;
  end
endmodule

// File: rtl/dit_datapath.sv
module dit_datapath
  import dit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     extIn,
  input  ctrlBus_t bus,
  output logic     irqA,
  output logic     irqB
);
  logic extS1, extS2, extS3, extRise;
  logic tickA, tickB, matchA, matchB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extS1 <= 1'b0;
      extS2 <= 1'b0;
      extS3 <= 1'b0;
    end else begin
      extS1 <= extIn;
      extS2 <= extS1;
      extS3 <= extS2;
    end
  end
  assign extRise = extS2 & ~extS3;

  always_comb begin
    case (bus.cfgA.sel)
      2'd0:    tickA = extRise;
      2'd1:    tickA = bus.taps.tick1;
      2'd2:    tickA = bus.taps.tick4;
      default: tickA = bus.taps.tick16;
    endcase
  end

  always_comb begin
    case (bus.cfgB.sel)
      2'd0:    tickB = matchA;
      2'd1:    tickB = bus.taps.tick1;
      2'd2:    tickB = bus.taps.tick16;
      default: tickB = bus.taps.tick256;
    endcase
  end

  dit_lane #(.CW(CNT_W)) uLaneA (
    .clk(clk), .rstN(rstN), .run(bus.cfgA.run), .tick(tickA),
    .cmp(bus.cfgA.cmp), .match(matchA), .irq(irqA)
  );

  dit_lane #(.CW(CNT_W)) uLaneB (
    .clk(clk), .rstN(rstN), .run(bus.cfgB.run), .tick(tickB),
    .cmp(bus.cfgB.cmp), .match(matchB), .irq(irqB)
  );

  logic unusedB;
  assign unusedB = matchB;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       extIn,
  output logic       irqA,
  output logic       irqB
);
  ctrlBus_t bus;

  dit_ctrl #(.BASE_DIV(BASE_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .bus(bus)
  );

  dit_datapath uData (
    .clk(clk), .rstN(rstN), .extIn(extIn), .bus(bus),
    .irqA(irqA), .irqB(irqB)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input ctrlBus_t bus,
  input logic     irqA,
  input logic     irqB
);
  assert_base_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    bus.taps.tick1 |=> !bus.taps.tick1);

  assert_pulse_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqA |=> !irqA);

  assert_pulse_b_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqB |=> !irqB);

  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!bus.cfgA.run && !$past(bus.cfgA.run)) |-> !irqA);

  assert_cascade_align_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqB && bus.cfgB.sel == 2'd0) |-> irqA);

  assert_cmp_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bus.cfgA.run && $past(bus.cfgA.run)) |-> $stable(bus.cfgA.cmp));

  assert_sel_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bus.cfgB.run && $past(bus.cfgB.run)) |-> $stable(bus.cfgB.sel));
endmodule

bind dual_interval_timer dit_checker uChk (
  .clk(clk), .rstN(rstN), .bus(bus), .irqA(irqA), .irqB(irqB)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic extIn = 1'b0;
  logic irqA, irqB;

  int cyc = 0;
  int checks = 0, fails = 0;
  int cntA = 0, cntB = 0, lastA = 0, lastB = 0, prevA = 0, prevB = 0;
  bit wasA = 0, wasB = 0, done = 0;

  dual_interval_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extIn(extIn), .irqA(irqA), .irqB(irqB)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irqA) begin
      prevA = lastA; lastA = cyc; cntA++;
      if (wasA) chk(0, "R8 irqA width", 2, 1);
    end
    if (irqB) begin
      prevB = lastB; lastB = cyc; cntB++;
      if (wasB) chk(0, "R8 irqB width", 2, 1);
    end
    wasA = irqA;
    wasB = irqB;
  end

  function automatic int divA(input int s);
    return (s == 1) ? 1 : (s == 2) ? 4 : 16;
  endfunction
  function automatic int divB(input int s);
    return (s == 1) ? 1 : (s == 2) ? 16 : 256;
  endfunction
  function automatic int expLat(input int div, input int c);
    return 4 * div * ((c == 0) ? 256 : c);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edgeCyc);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 edgeCyc = cyc;
    wrEn = 1'b0;
  endtask

  task automatic waitA(input int target, input int limit);
    int k = 0;
    while (cntA < target && k < limit) begin
      @(negedge clk); #1; k++;
    end
  endtask
  task automatic waitB(input int target, input int limit);
    int k = 0;
    while (cntB < target && k < limit) begin
      @(negedge clk); #1; k++;
    end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic measureA(input int s, input int c, input string req);
    int w, e, b;
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'(s), w);
    wr(2'd2, 8'(c), w);
    wr(2'd0, 8'h01, w);
    e = expLat(divA(s), c);
    b = cntA;
    waitA(b + 1, e + 40);
    chk(cntA == b + 1 && lastA - w == e, req, lastA - w, e);
    waitA(b + 2, e + 40);
    chk(cntA == b + 2 && lastA - prevA == e, req, lastA - prevA, e);
  endtask

  task automatic measureB(input int s, input int c, input string req);
    int w, e, b;
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'(s << 2), w);
    wr(2'd3, 8'(c), w);
    wr(2'd0, 8'h02, w);
    e = expLat(divB(s), c);
    b = cntB;
    waitB(b + 1, e + 40);
    chk(cntB == b + 1 && lastB - w == e, req, lastB - w, e);
    waitB(b + 2, e + 40);
    chk(cntB == b + 2 && lastB - prevB == e, req, lastB - prevB, e);
  endtask

  task automatic pulse(input int hi);
    @(negedge clk); extIn = 1'b1;
    repeat (hi) @(negedge clk);
    extIn = 1'b0;
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int w, b, s, c;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state and quiet outputs
    chk(irqA == 0 && irqB == 0, "R1 reset outputs", int'(irqA) + int'(irqB), 0);
    wr(2'd2, 8'd1, w);
    idle(300);
    chk(cntA == 0 && cntB == 0, "R1 no pulses while stopped", cntA + cntB, 0);

    // R2 divide-by-1 tap on timer A
    measureA(1, 5, "R2 A div1 latency/period");
    // R3 other A taps
    measureA(2, 6, "R3 A div4");
    measureA(3, 3, "R3 A div16");
    // R4 B taps
    measureB(1, 9, "R4 B div1");
    measureB(2, 3, "R4 B div16");
    measureB(3, 2, "R4 B div256");
    // R5 compare zero means 256
    measureA(1, 0, "R5 A cmp0");
    measureB(1, 0, "R5 B cmp0");

    // R7 cascade: A div1 cmp3, B from A matches cmp4
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'h01, w);
    wr(2'd2, 8'd3, w);
    wr(2'd3, 8'd4, w);
    b = cntB;
    wr(2'd0, 8'h03, w);
    waitB(b + 1, 200);
    chk(cntB == b + 1 && lastB - w == 48, "R7 cascade first irqB", lastB - w, 48);
    waitB(b + 2, 200);
    chk(lastB - prevB == 48, "R7 cascade period", lastB - prevB, 48);
    chk(lastA == lastB, "R7 irqB with irqA", lastA, lastB);

    // R12 both running independently
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'h05, w);
    wr(2'd2, 8'd5, w);
    wr(2'd3, 8'd7, w);
    b = cntB;
    wr(2'd0, 8'h03, w);
    waitB(b + 1, 200);
    chk(lastB - w == 28, "R12 B latency beside A", lastB - w, 28);
    waitB(b + 2, 200);
    chk(lastB - prevB == 28, "R12 B period", lastB - prevB, 28);
    chk(lastA - prevA == 20, "R12 A period", lastA - prevA, 20);

    // R8 repeated pulses while running
    b = cntA;
    idle(200);
    chk(cntA == b + 10, "R8 repeat count", cntA - b, 10);

    // R9 stop clears count; B keeps prescaler alive
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'h09, w);
    wr(2'd2, 8'd10, w);
    wr(2'd3, 8'd50, w);
    wr(2'd0, 8'h03, w);
    idle(22);
    wr(2'd0, 8'h02, w);
    b = cntA;
    idle(60);
    chk(cntA == b, "R9 stopped is quiet", cntA - b, 0);
    wr(2'd0, 8'h03, w);
    waitA(b + 1, 100);
    chk(lastA - w >= 37 && lastA - w <= 40, "R9 full period after restart", lastA - w, 40);

    // R10 compare write ignored while running, live when stopped
    measureA(1, 5, "R10 setup");
    wr(2'd2, 8'd9, w);
    b = cntA;
    waitA(b + 2, 100);
    chk(lastA - prevA == 20, "R10 running cmp write ignored", lastA - prevA, 20);
    wr(2'd0, 8'h00, w);
    wr(2'd2, 8'd9, w);
    b = cntA;
    wr(2'd0, 8'h01, w);
    waitA(b + 1, 100);
    chk(lastA - w == 36, "R10 stopped cmp write applied", lastA - w, 36);

    // R11 select write ignored while running
    wr(2'd1, 8'h03, w);
    b = cntA;
    waitA(b + 2, 200);
    chk(lastA - prevA == 36, "R11 running sel write ignored", lastA - prevA, 36);

    // R6 external edges only
    wr(2'd0, 8'h00, w);
    wr(2'd1, 8'h00, w);
    wr(2'd2, 8'd3, w);
    wr(2'd0, 8'h01, w);
    b = cntA;
    pulse(3);
    pulse(3);
    idle(20);
    chk(cntA == b, "R6 two edges no match", cntA - b, 0);
    pulse(20);
    chk(cntA == b + 1, "R6 third edge matches", cntA - b, 1);
    pulse(2);
    pulse(30);
    chk(cntA == b + 1, "R6 held level counts once", cntA - b, 1);
    pulse(2);
    chk(cntA == b + 2, "R6 second match", cntA - b, 2);

    // random mix, R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      s = 1 + int'($urandom_range(2));
      c = 1 + int'($urandom_range(29));
      measureA(s, c, "R3 random A");
      s = 1 + int'($urandom_range(1));
      c = 1 + int'($urandom_range(19));
      measureB(s, c, "R4 random B");
    end

    wr(2'd0, 8'h00, w);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule